// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two levels of state. The first level is a record of recent branch outcomes. A build parameter picks one of two forms for it: a single shift register shared by every branch, or a small table of shift registers selected by low program-counter bits. The second level is a table of 2-bit saturating counters. The counter used for a branch is picked by XOR-ing the selected outcome record with program-counter bits. This lets the block learn branches that repeat a pattern and branches whose outcome follows the outcome of earlier ones.

The fetch stage presents a branch address on the lookup side and reads a taken/not-taken guess in the same cycle, with no register in between. When the branch resolves, the execute stage presents its address and real outcome on the update side. At the next clock edge the selected counter is trained, and the new outcome is shifted into the outcome record. The counter that is trained is the one chosen by the record as it stood before that shift.

Top module: `branch_dir_predictor`

## Requirements
- R1: After reset every counter holds 1 (weakly not taken) and every outcome record holds 0, so each lookup address gets a not-taken guess until the first update.
- R2: The guess is taken exactly when the selected counter holds 2 or 3, and not taken when it holds 0 or 1 (the counter's upper bit).
- R3: The counter index is the selected outcome record XOR address bits [HIST_BITS+1:2]. With the defaults that is a 4-bit record XOR PC[5:2], giving 16 counters.
- R4: An update with a taken outcome adds one to the selected counter, and a counter at 3 stays at 3.
- R5: An update with a not-taken outcome subtracts one from the selected counter, and a counter at 0 stays at 0.
- R6: The counter trained by an update is the one indexed by the outcome record as it was before the outcome of that update is shifted in.
- R7: An update shifts its outcome (1 = taken) into bit 0 of the outcome record; the older bits move up one place and the oldest bit is dropped.
- R8: With USE_LOCAL = 0, one record is shared: every update shifts it, whatever its address.
- R9: With USE_LOCAL = 1, the record is chosen from a 16-entry table by PC[5:2], for both lookup and update; an update shifts only the entry its own address selects.
- R10: While the update valid input is low, no counter and no outcome record changes, whatever the other update inputs carry.
- R11: The guess follows the lookup address in the same cycle, and an update becomes visible to lookups only after the clock edge that applies it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupPc | input | PC_W | Address of the branch being fetched |
| lookupTaken | output | 1 | Direction guess for lookupPc, 1 = taken |
| updValid | input | 1 | An update is presented this cycle |
| updPc | input | PC_W | Address of the resolved branch |
| updTaken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The guess is a combinational function of the lookup address and of state, so it is due in the cycle the address is presented. The effect of an update is due one edge later. The bench drives both sides on the falling edge and samples the guess 1 ns later. It then advances its reference model only after the rising edge that applies the update. That way each sampled guess is compared against the state as it stood before that cycle's update. One global-mode and one local-mode instance run the same stimulus.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;

  // Strobes from the control to the datapath for one update.
  typedef struct packed {
    logic trainEn;   // train the selected counter
    logic stepUp;    // 1: count up, 0: count down
    logic shiftEn;   // shift the outcome record
    logic shiftBit;  // bit shifted into the record
  } dirpredCtrl_t;

  localparam int unsigned CTR_W   = 2;
  localparam logic [1:0]  CTR_MAX = 2'd3;
  localparam logic [1:0]  CTR_MIN = 2'd0;
  localparam logic [1:0]  CTR_RST = 2'd1;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic up);
    if (up) return (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
    else    return (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
  endfunction

endpackage

// File: rtl/dirpred_ctrl.sv
module dirpred_ctrl
  import dirpred_pkg::*;
(
  input  logic         updValid,
  input  logic         updTaken,
  output dirpredCtrl_t ctrl
);

  always_comb begin
    ctrl          = '0;
    ctrl.trainEn  = updValid;
    ctrl.stepUp   = updTaken;
    ctrl.shiftEn  = updValid;
    ctrl.shiftBit = updTaken;
  end

endmodule

// File: rtl/dirpred_history.sv
module dirpred_history #(
  parameter int unsigned HIST_BITS    = 4,
  parameter int unsigned LHT_IDX_BITS = 4,
  parameter bit          USE_LOCAL    = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LHT_IDX_BITS-1:0] lookupSel,
  input  logic [LHT_IDX_BITS-1:0] updSel,
  input  logic                    shiftEn,
  input  logic                    shiftBit,
  output logic [HIST_BITS-1:0]    lookupHist,
  output logic [HIST_BITS-1:0]    updHist
);

  localparam int unsigned LHT_DEPTH = 1 << LHT_IDX_BITS;

  function automatic logic [HIST_BITS-1:0] pushBit(input logic [HIST_BITS-1:0] h,
                                                   input logic b);
    logic [HIST_BITS:0] wide;
    wide = {h, b};
    return wide[HIST_BITS-1:0];
  endfunction

  generate
    if (USE_LOCAL) begin : g_local
      logic [HIST_BITS-1:0] histTab [LHT_DEPTH];

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          for (int i = 0; i < LHT_DEPTH; i++) histTab[i] <= '0;
        end else if (shiftEn) begin
          histTab[updSel] <= pushBit(histTab[updSel], shiftBit);
        end
      end

      assign lookupHist = histTab[lookupSel];
      assign updHist    = histTab[updSel];
    end else begin : g_global
      logic [HIST_BITS-1:0] sharedHist;
      logic                 unusedSel;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        sharedHist <= '0;
        else if (shiftEn) sharedHist <= pushBit(sharedHist, shiftBit);
      end

      assign unusedSel  = ^{lookupSel, updSel};
      assign lookupHist = sharedHist;
      assign updHist    = sharedHist;
    end
  endgenerate

endmodule

// File: rtl/dirpred_pht.sv
module dirpred_pht
  import dirpred_pkg::*;
#(
  parameter int unsigned IDX_BITS = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [IDX_BITS-1:0]                lookupIdx,
  input  logic [IDX_BITS-1:0]                trainIdx,
  input  logic                               trainEn,
  input  logic                               stepUp,
  output logic [CTR_W-1:0]                   lookupCtr,
  output logic [CTR_W-1:0]                   trainCtr,
  output logic [(1<<IDX_BITS)-1:0][CTR_W-1:0] phtState
);

  localparam int unsigned DEPTH = 1 << IDX_BITS;

  logic [CTR_W-1:0] ctrTab [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ctrTab[i] <= CTR_RST;
    end else if (trainEn) begin
      ctrTab[trainIdx] <= satStep(ctrTab[trainIdx], stepUp);
    end
  end

  assign lookupCtr = ctrTab[lookupIdx];
  assign trainCtr  = ctrTab[trainIdx];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign phtState[g] = ctrTab[g];
    end
  endgenerate

endmodule

// File: rtl/dirpred_datapath.sv
module dirpred_datapath
  import dirpred_pkg::*;
#(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned HIST_BITS    = 4,
  parameter int unsigned LHT_IDX_BITS = 4,
  parameter bit          USE_LOCAL    = 1'b0
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  dirpredCtrl_t                         ctrl,
  input  logic [PC_W-1:0]                      lookupPc,
  input  logic [PC_W-1:0]                      updPc,
  output logic                                 lookupTaken,
  output logic [HIST_BITS-1:0]                 trainIdx,
  output logic [CTR_W-1:0]                     trainCtr,
  output logic [(1<<HIST_BITS)-1:0][CTR_W-1:0] phtState
);

  localparam int unsigned PC_LO    = 2;
  localparam int unsigned PC_HI    = PC_LO + HIST_BITS - 1;
  localparam int unsigned SEL_HI   = PC_LO + LHT_IDX_BITS - 1;
  localparam int unsigned TOP_USED = (PC_HI > SEL_HI) ? PC_HI : SEL_HI;

  logic [HIST_BITS-1:0] lookupHist;
  logic [HIST_BITS-1:0] updHist;
  logic [HIST_BITS-1:0] lookupIdx;
  logic [CTR_W-1:0]     lookupCtr;
  logic                 unusedPcBits;

  dirpred_history #(
    .HIST_BITS   (HIST_BITS),
    .LHT_IDX_BITS(LHT_IDX_BITS),
    .USE_LOCAL   (USE_LOCAL)
  ) u_history (
    .clk       (clk),
    .rstN      (rstN),
    .lookupSel (lookupPc[SEL_HI:PC_LO]),
    .updSel    (updPc[SEL_HI:PC_LO]),
    .shiftEn   (ctrl.shiftEn),
    .shiftBit  (ctrl.shiftBit),
    .lookupHist(lookupHist),
    .updHist   (updHist)
  );

  // Pattern index: outcome record folded with address bits.
  assign lookupIdx = lookupHist ^ lookupPc[PC_HI:PC_LO];
  assign trainIdx  = updHist    ^ updPc[PC_HI:PC_LO];

  dirpred_pht #(
    .IDX_BITS(HIST_BITS)
  ) u_pht (
    .clk      (clk),
    .rstN     (rstN),
    .lookupIdx(lookupIdx),
    .trainIdx (trainIdx),
    .trainEn  (ctrl.trainEn),
    .stepUp   (ctrl.stepUp),
    .lookupCtr(lookupCtr),
    .trainCtr (trainCtr),
    .phtState (phtState)
  );

  assign lookupTaken = lookupCtr[CTR_W-1];

  generate
    if (TOP_USED + 1 < PC_W) begin : g_hiUnused
      assign unusedPcBits = ^{lookupPc[PC_W-1:TOP_USED+1], updPc[PC_W-1:TOP_USED+1],
                              lookupPc[PC_LO-1:0], updPc[PC_LO-1:0]};
    end else begin : g_loUnused
      assign unusedPcBits = ^{lookupPc[PC_LO-1:0], updPc[PC_LO-1:0]};
    end
  endgenerate

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import dirpred_pkg::*;
#(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned HIST_BITS    = 4,
  parameter int unsigned LHT_IDX_BITS = 4,
  parameter bit          USE_LOCAL    = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PC_W-1:0] lookupPc,
  output logic            lookupTaken,
  input  logic            updValid,
  input  logic [PC_W-1:0] updPc,
  input  logic            updTaken
);

  dirpredCtrl_t                         ctrl;
  logic [HIST_BITS-1:0]                 trainIdx;
  logic [CTR_W-1:0]                     trainCtr;
  logic [(1<<HIST_BITS)-1:0][CTR_W-1:0] phtState;

  dirpred_ctrl u_ctrl (
    .updValid(updValid),
    .updTaken(updTaken),
    .ctrl    (ctrl)
  );

  dirpred_datapath #(
    .PC_W        (PC_W),
    .HIST_BITS   (HIST_BITS),
    .LHT_IDX_BITS(LHT_IDX_BITS),
    .USE_LOCAL   (USE_LOCAL)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .lookupPc   (lookupPc),
    .updPc      (updPc),
    .lookupTaken(lookupTaken),
    .trainIdx   (trainIdx),
    .trainCtr   (trainCtr),
    .phtState   (phtState)
  );

endmodule

// File: rtl/dirpred_checker.sv
module dirpred_checker #(
  parameter int unsigned HIST_BITS = 4
) (
  input logic                                 clk,
  input logic                                 rstN,
  input logic                                 lookupTaken,
  input logic                                 updValid,
  input logic                                 updTaken,
  input logic [HIST_BITS-1:0]                 trainIdx,
  input logic [1:0]                           trainCtr,
  input logic [(1<<HIST_BITS)-1:0][1:0]       phtState
);

  logic seenUpdate;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         seenUpdate <= 1'b0;
    else if (updValid) seenUpdate <= 1'b1;
  end

  // R1: no guess is taken before the first update
  p_reset_guess_r1: assert property (@(posedge clk) disable iff (!rstN)
    !seenUpdate |-> !lookupTaken);

  // R4: taken step, saturating at 3
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && updTaken) |=>
      phtState[$past(trainIdx)] == (($past(trainCtr) == 2'd3) ? 2'd3 : $past(trainCtr) + 2'd1));

  // R5: not-taken step, saturating at 0
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    (updValid && !updTaken) |=>
      phtState[$past(trainIdx)] == (($past(trainCtr) == 2'd0) ? 2'd0 : $past(trainCtr) - 2'd1));

  // R10: no update, no counter change
  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(phtState));

  // R4/R5: at most one counter changes per edge
  p_single_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(phtState ^ $past(phtState)) <= 2);

endmodule

bind branch_dir_predictor dirpred_checker #(.HIST_BITS(HIST_BITS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .lookupTaken(lookupTaken),
  .updValid   (updValid),
  .updTaken   (updTaken),
  .trainIdx   (trainIdx),
  .trainCtr   (trainCtr),
  .phtState   (phtState)
);

// File: tb/branch_dir_predictor_bench.sv
`timescale 1ns/1ps
module branch_dir_predictor_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lookupPc = '0;
  logic [31:0] updPc = '0;
  logic        updValid = 1'b0;
  logic        updTaken = 1'b0;
  logic        takenGlb;
  logic        takenLoc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state: [0] global mode, [1] local mode
  int          refPht [2][16];
  logic [3:0]  refGhr;
  logic [3:0]  refLht [16];

  always #5 clk = ~clk;

  branch_dir_predictor #(.USE_LOCAL(1'b0)) u_branch_dir_predictor (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .lookupTaken(takenGlb),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  branch_dir_predictor #(.USE_LOCAL(1'b1)) u_branch_dir_predictor_loc (
    .clk(clk), .rstN(rstN), .lookupPc(lookupPc), .lookupTaken(takenLoc),
    .updValid(updValid), .updPc(updPc), .updTaken(updTaken));

  function automatic logic [3:0] refIdx(int mode, logic [31:0] pc);
    logic [3:0] h;
    h = (mode == 1) ? refLht[pc[5:2]] : refGhr;
    return h ^ pc[5:2];
  endfunction

  function automatic logic refGuess(int mode, logic [31:0] pc);
    return refPht[mode][refIdx(mode, pc)] >= 2;
  endfunction

  task automatic refReset();
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 16; i++) refPht[m][i] = 1;
    refGhr = '0;
    for (int i = 0; i < 16; i++) refLht[i] = '0;
  endtask

  task automatic refTrain(logic [31:0] pc, logic tk);
    for (int m = 0; m < 2; m++) begin
      int idx;
      idx = refIdx(m, pc);
      if (tk) refPht[m][idx] = (refPht[m][idx] == 3) ? 3 : refPht[m][idx] + 1;
      else    refPht[m][idx] = (refPht[m][idx] == 0) ? 0 : refPht[m][idx] - 1;
    end
    refGhr = {refGhr[2:0], tk};
    refLht[pc[5:2]] = {refLht[pc[5:2]][2:0], tk};
  endtask

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pc=%h actual=%0b expected=%0b", tag, lookupPc, act, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check the guess, then the edge applies the update.
  task automatic step(string tag, logic [31:0] lpc, logic uv, logic [31:0] upc, logic tk);
    @(negedge clk);
    lookupPc = lpc; updValid = uv; updPc = upc; updTaken = tk;
    #1;
    check({tag, " global"}, takenGlb, refGuess(0, lpc));
    check({tag, " local"},  takenLoc, refGuess(1, lpc));
    @(posedge clk);
    if (uv) refTrain(upc, tk);
  endtask

  task automatic sweep(string tag);
    for (int p = 0; p < 16; p++) step(tag, 32'h1000 + p * 4, 1'b0, '0, 1'b0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd1234);
    refReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: all guesses not taken after reset
    sweep("R1 reset");

    // R4, R6, R7, R8: repeated taken updates saturate; lookups follow the record
    for (int i = 0; i < 8; i++) step("R4 sat-up", 32'h0, 1'b1, 32'h40, 1'b1);
    sweep("R4/R3 after taken run");
    step("R2 guess pc0", 32'h40, 1'b0, '0, 1'b0);

    // R5: repeated not-taken updates saturate at 0
    for (int i = 0; i < 10; i++) step("R5 sat-down", 32'h40, 1'b1, 32'h40, 1'b0);
    sweep("R5/R7 after not-taken run");

    // R9: local entries train independently, alternating pattern on one address
    for (int i = 0; i < 12; i++) step("R9 pattern", 32'h8, 1'b1, 32'h8, i[0]);
    for (int i = 0; i < 6; i++)  step("R9 other", 32'hC, 1'b1, 32'h4, 1'b1);
    sweep("R8/R9 after patterns");

    // R11: update and lookup to the same counter in one cycle
    step("R11 same-cycle", 32'h4, 1'b1, 32'h4, 1'b1);
    step("R11 next-cycle", 32'h4, 1'b0, '0, 1'b0);

    // R10: invalid updates with live data leave everything unchanged
    for (int i = 0; i < 20; i++) step("R10 invalid", $urandom, 1'b0, $urandom, $urandom % 2);
    sweep("R10 after invalid");

    // R2/R3/R6: random traffic, biased address set
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] lp, up;
      lp = {$urandom % 64, 2'b00};
      up = {$urandom % 64, 2'b00};
      step("R2/R3/R6 random", lp, ($urandom % 4) != 0, up, ($urandom % 3) != 0);
    end

    // R1: reset again restores weak not-taken
    @(negedge clk);
    rstN = 1'b0; updValid = 1'b0;
    refReset();
    @(negedge clk);
    rstN = 1'b1;
    sweep("R1 re-reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule